// File: doc/BRIEF.md
# Byte-Paired Compare Value Staging

This block stages a compare value that is wider than the peripheral bus that writes it. Software writes the value one byte at a time, using separate high-byte and low-byte write strobes that share one data bus. Each byte lands in a shadow buffer. The active compare value changes only after both halves of a new pair have arrived, so a counter comparing against it never sees a half-updated value.

The transfer is timed by the counter clock-select field. When the field is zero, the counter is stopped and the active value loads on the edge of the write that completes the pair. When the field is nonzero, the completed value is held as pending and loads on the next prescaler tick that comes after the pair completes. A write to the channel control register clears the record of which bytes have been written, so software can restart a pair. Each transfer produces a one-cycle load pulse. The counter, the prescaler and interrupt generation are outside this block; the `presTick` input stands in for the counter advance.

Top module: `cmp_byte_buffer`

## Requirements
- R1: After reset, `activeVal` is 0 and `loadPulse` is 0, and no byte is counted as written, so a single byte write after reset does not change `activeVal`.
- R2: A byte write alone only updates the shadow buffer. `activeVal` changes only on a transfer.
- R3: With `clkSel` equal to 0, the write that completes a pair loads `{high byte, low byte}` into `activeVal` on that same clock edge, and `loadPulse` is 1 for the following cycle.
- R4: With `clkSel` nonzero, a completed pair becomes pending and loads on the first `presTick` in a later cycle. A tick in the same cycle as the completing write does not load it, and a tick with nothing pending loads nothing.
- R5: `wrCtrl` clears both byte-written flags. A byte write in the same cycle as `wrCtrl` stores its data but does not count toward a pair.
- R6: The high and low bytes may be written in either order, or together in one cycle. Both flags clear when a pair completes, so the next single byte does not trigger a transfer.
- R7: Writing the same byte twice before its partner replaces that byte in the buffer and does not complete a pair.
- R8: While a pair is pending, new byte writes start a fresh pair. The pending transfer carries the most recently completed pair.
- R9: `loadPulse` is high for exactly the cycle after each transfer. `wrCtrl` does not cancel a pending transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrHi | input | 1 | High-byte write strobe |
| wrLo | input | 1 | Low-byte write strobe |
| wrData | input | BYTE_W | Byte write data |
| wrCtrl | input | 1 | Channel control register write strobe |
| clkSel | input | CS_W | Counter clock select; 0 means the counter is stopped |
| presTick | input | 1 | One-cycle pulse when the counter advances |
| activeVal | output | 2*BYTE_W | Active compare value |
| loadPulse | output | 1 | One-cycle pulse after each transfer |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, which give a 16-bit value, and a 2-bit clock select. With these values every clock-select code (stopped and three running codes) can be driven, and byte values such as 0xFF and 0x00 cover both extremes of each lane. The stimulus concentrates on timing collisions: a tick in the same cycle as the completing write, a control write in the same cycle as a byte write, a new pair starting while another is pending, and a control write landing while a transfer is pending.

// File: rtl/cmpbuf_pkg.sv
package cmpbuf_pkg;

  // Strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic storeHi;     // capture wrData into the high shadow byte
    logic storeLo;     // capture wrData into the low shadow byte
    logic immLoad;     // load active from the just-completed shadow pair
    logic pendCapture; // hold the just-completed pair as pending
    logic pendLoad;    // load active from the pending value
  } cmpStrobe_t;

endpackage

// File: rtl/cmpbuf_ctrl.sv
module cmpbuf_ctrl
  import cmpbuf_pkg::*;
#(
  parameter int CS_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrHi,
  input  logic            wrLo,
  input  logic            wrCtrl,
  input  logic [CS_W-1:0] clkSel,
  input  logic            presTick,
  output cmpStrobe_t      strobe,
  output logic            loadPulse
);

  logic hiSeen, loSeen, pendValid;
  logic hiNow, loNow, pairDone, counterStopped;

  assign counterStopped = (clkSel == '0);
  // A byte written together with a control write stores data but does not count
  assign hiNow    = hiSeen | (wrHi & ~wrCtrl);
  assign loNow    = loSeen | (wrLo & ~wrCtrl);
  assign pairDone = hiNow & loNow & (wrHi | wrLo) & ~wrCtrl;

  always_comb begin
    strobe.storeHi     = wrHi;
    strobe.storeLo     = wrLo;
    strobe.immLoad     = pairDone & counterStopped;
    strobe.pendCapture = pairDone & ~counterStopped;
    strobe.pendLoad    = pendValid & presTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiSeen    <= 1'b0;
      loSeen    <= 1'b0;
      pendValid <= 1'b0;
      loadPulse <= 1'b0;
    end else begin
      if (wrCtrl || pairDone) begin
        hiSeen <= 1'b0;
        loSeen <= 1'b0;
      end else begin
        hiSeen <= hiNow;
        loSeen <= loNow;
      end
      if (strobe.pendCapture)   pendValid <= 1'b1;
      else if (strobe.pendLoad) pendValid <= 1'b0;
      loadPulse <= strobe.immLoad | strobe.pendLoad;
    end
  end

  // R5: a control write leaves no byte counted
  assert_ctrl_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> (!hiSeen && !loSeen));

  // R6: a completed pair leaves both flags clear
  assert_flags_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    pairDone |=> (!hiSeen && !loSeen));

  // R3: stopped counter loads on the completing write
  assert_stopped_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pairDone && counterStopped) |=> loadPulse);

  // R4: a tick with a pending pair produces a load
  assert_tick_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && presTick) |=> loadPulse);

  // R9: a control write does not drop a pending transfer
  assert_ctrl_keeps_pend_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && pendValid && !presTick) |=> pendValid);

endmodule

// File: rtl/cmpbuf_dpath.sv
module cmpbuf_dpath
  import cmpbuf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BYTE_W-1:0]   wrData,
  input  cmpStrobe_t          strobe,
  output logic [2*BYTE_W-1:0] activeVal
);

  localparam int VAL_W = 2 * BYTE_W;
  localparam int LANES = 2;

  logic [LANES-1:0]  laneStore;
  logic [VAL_W-1:0]  shadowQ, shadowNext, pendVal;

  assign laneStore = {strobe.storeHi, strobe.storeLo};

  // Lane 0 is the low byte, lane 1 the high byte
  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    assign shadowNext[lane*BYTE_W +: BYTE_W] =
      laneStore[lane] ? wrData : shadowQ[lane*BYTE_W +: BYTE_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shadowQ[lane*BYTE_W +: BYTE_W] <= '0;
      else       shadowQ[lane*BYTE_W +: BYTE_W] <= shadowNext[lane*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendVal   <= '0;
      activeVal <= '0;
    end else begin
      if (strobe.pendCapture) pendVal <= shadowNext;
      if (strobe.immLoad)       activeVal <= shadowNext;
      else if (strobe.pendLoad) activeVal <= pendVal;
    end
  end

  // R2: without a transfer strobe the active value holds
  assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.immLoad || strobe.pendLoad) |=> $stable(activeVal));

  // R8: the pending value moves only on a new completed pair
  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pendCapture |=> $stable(pendVal));

endmodule

// File: rtl/cmp_byte_buffer.sv
module cmp_byte_buffer
  import cmpbuf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CS_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrHi,
  input  logic                wrLo,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic                wrCtrl,
  input  logic [CS_W-1:0]     clkSel,
  input  logic                presTick,
  output logic [2*BYTE_W-1:0] activeVal,
  output logic                loadPulse
);

  cmpStrobe_t strobe;

  cmpbuf_ctrl #(.CS_W(CS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrHi(wrHi), .wrLo(wrLo), .wrCtrl(wrCtrl),
    .clkSel(clkSel), .presTick(presTick), .strobe(strobe), .loadPulse(loadPulse)
  );

  cmpbuf_dpath #(.BYTE_W(BYTE_W)) uDpath (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobe(strobe), .activeVal(activeVal)
  );

  // R9: a load pulse always comes with a changed or reloaded value source
  assert_pulse_after_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.immLoad || strobe.pendLoad) |=> loadPulse);

endmodule

// File: tb/sim_cmp_byte_buffer.sv
module sim_cmp_byte_buffer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrHi = 1'b0, wrLo = 1'b0, wrCtrl = 1'b0, presTick = 1'b0;
  logic [7:0]  wrData = '0;
  logic [1:0]  clkSel = '0;
  logic [15:0] activeVal;
  logic        loadPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_byte_buffer u0 (
    .clk(clk), .rstN(rstN), .wrHi(wrHi), .wrLo(wrLo), .wrData(wrData),
    .wrCtrl(wrCtrl), .clkSel(clkSel), .presTick(presTick),
    .activeVal(activeVal), .loadPulse(loadPulse)
  );

  // {req[3:0], hi, lo, ctl, data[7:0], cs[1:0], tick, expActive[15:0], expPulse}
  localparam int NV = 26;
  localparam logic [34:0] VEC [NV] = '{
    {4'd2, 1'b1,1'b0,1'b0, 8'h12, 2'd0, 1'b0, 16'h0000, 1'b0}, // R2 lone high byte
    {4'd3, 1'b0,1'b1,1'b0, 8'h34, 2'd0, 1'b0, 16'h1234, 1'b1}, // R3 immediate load
    {4'd6, 1'b0,1'b1,1'b0, 8'h56, 2'd0, 1'b0, 16'h1234, 1'b0}, // R6 low first
    {4'd6, 1'b1,1'b0,1'b0, 8'h78, 2'd0, 1'b0, 16'h7856, 1'b1}, // R6 then high
    {4'd6, 1'b1,1'b0,1'b0, 8'hAA, 2'd0, 1'b0, 16'h7856, 1'b0}, // R6 flags cleared
    {4'd7, 1'b1,1'b0,1'b0, 8'hBB, 2'd0, 1'b0, 16'h7856, 1'b0}, // R7 high again
    {4'd7, 1'b0,1'b1,1'b0, 8'hCC, 2'd0, 1'b0, 16'hBBCC, 1'b1}, // R7 overwritten byte used
    {4'd2, 1'b1,1'b0,1'b0, 8'h11, 2'd0, 1'b0, 16'hBBCC, 1'b0}, // R2
    {4'd5, 1'b0,1'b0,1'b1, 8'h00, 2'd0, 1'b0, 16'hBBCC, 1'b0}, // R5 control write
    {4'd5, 1'b0,1'b1,1'b0, 8'h22, 2'd0, 1'b0, 16'hBBCC, 1'b0}, // R5 high no longer counted
    {4'd5, 1'b1,1'b0,1'b0, 8'h33, 2'd0, 1'b0, 16'h3322, 1'b1}, // R5 fresh pair
    {4'd4, 1'b1,1'b0,1'b0, 8'h44, 2'd1, 1'b0, 16'h3322, 1'b0}, // R4 running counter
    {4'd4, 1'b0,1'b1,1'b0, 8'h55, 2'd1, 1'b0, 16'h3322, 1'b0}, // R4 pair pending
    {4'd4, 1'b0,1'b0,1'b0, 8'h00, 2'd1, 1'b0, 16'h3322, 1'b0}, // R4 no tick yet
    {4'd4, 1'b0,1'b0,1'b0, 8'h00, 2'd1, 1'b1, 16'h4455, 1'b1}, // R4 tick loads
    {4'd9, 1'b0,1'b0,1'b0, 8'h00, 2'd1, 1'b1, 16'h4455, 1'b0}, // R9 one pulse only
    {4'd4, 1'b1,1'b0,1'b0, 8'h66, 2'd2, 1'b1, 16'h4455, 1'b0}, // R4 tick, nothing pending
    {4'd4, 1'b0,1'b1,1'b0, 8'h77, 2'd2, 1'b1, 16'h4455, 1'b0}, // R4 tick with completing write
    {4'd8, 1'b1,1'b0,1'b0, 8'h88, 2'd2, 1'b0, 16'h4455, 1'b0}, // R8 new pair while pending
    {4'd8, 1'b0,1'b0,1'b0, 8'h00, 2'd2, 1'b1, 16'h6677, 1'b1}, // R8 pending keeps old pair
    {4'd8, 1'b0,1'b1,1'b0, 8'h99, 2'd2, 1'b0, 16'h6677, 1'b0}, // R8 second pair completes
    {4'd4, 1'b0,1'b0,1'b0, 8'h00, 2'd3, 1'b1, 16'h8899, 1'b1}, // R4 code 3
    {4'd9, 1'b1,1'b0,1'b0, 8'h01, 2'd1, 1'b0, 16'h8899, 1'b0}, // R9
    {4'd9, 1'b0,1'b1,1'b0, 8'h02, 2'd1, 1'b0, 16'h8899, 1'b0}, // R9 pending
    {4'd9, 1'b0,1'b0,1'b1, 8'h00, 2'd1, 1'b0, 16'h8899, 1'b0}, // R9 control write while pending
    {4'd9, 1'b0,1'b0,1'b0, 8'h00, 2'd1, 1'b1, 16'h0102, 1'b1}  // R9 pending survived
  };

  task automatic check(input string tag, input logic [15:0] expA, input logic expP);
    checks++;
    if (activeVal !== expA || loadPulse !== expP) begin
      errors++;
      $display("FAIL %s active=%h exp=%h pulse=%b exp=%b", tag, activeVal, expA, loadPulse, expP);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input logic hi, input logic lo, input logic ctl, input logic [7:0] d,
                      input logic [1:0] cs, input logic tk);
    wrHi = hi; wrLo = lo; wrCtrl = ctl; wrData = d; clkSel = cs; presTick = tk;
    @(posedge clk);
    @(negedge clk);
    wrHi = 1'b0; wrLo = 1'b0; wrCtrl = 1'b0; presTick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 16'h0000, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 16'h0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      step(v[30], v[29], v[28], v[27:20], v[19:18], v[17]);
      check($sformatf("R%0d row %0d", v[34:31], i), v[16:1], v[0]);
    end

    // R5: byte write together with control write does not count
    step(1'b1, 1'b0, 1'b1, 8'hAB, 2'd0, 1'b0);
    check("R5 ctl+hi", 16'h0102, 1'b0);
    step(1'b0, 1'b1, 1'b0, 8'hCD, 2'd0, 1'b0);
    check("R5 lone low", 16'h0102, 1'b0);
    step(1'b1, 1'b0, 1'b0, 8'hEF, 2'd0, 1'b0);
    check("R5 pair done", 16'hEFCD, 1'b1);

    // R6: both bytes in one cycle
    step(1'b1, 1'b1, 1'b0, 8'h5A, 2'd0, 1'b0);
    check("R6 both bytes", 16'h5A5A, 1'b1);
    step(1'b0, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0);
    check("R9 pulse drops", 16'h5A5A, 1'b0);

    // R6: extreme byte values
    step(1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 8'hFF, 2'd0, 1'b0);
    check("R6 FF00", 16'hFF00, 1'b1);

    // R1: reset mid-pair clears flags and values
    step(1'b1, 1'b0, 1'b0, 8'h12, 2'd0, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset again", 16'h0000, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    step(1'b0, 1'b1, 1'b0, 8'h34, 2'd0, 1'b0);
    check("R1 flags cleared by reset", 16'h0000, 1'b0);
    step(1'b1, 1'b0, 1'b0, 8'h12, 2'd0, 1'b0);
    check("R3 after reset", 16'h1234, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule